// File: doc/BRIEF.md
# File-Register Rotate, Subtract and Swap Execute Unit

This block is the execute step of a small 8-bit core built around one working register. Each issued operation takes a byte from a 32-entry file-register array, combines it with the working-register value and the incoming status flags, and produces a result byte together with new carry, digit-carry and zero flags. The four operations are a left rotate through carry, a right rotate through carry, subtraction of the working register from the file byte, and an exchange of the two nibbles.

A destination bit picks where the result lands. When it is 1 the result is written back into the addressed file entry on the same clock edge. When it is 0 the file is left alone and a write strobe tells the surrounding core to load the working register. Each operation changes only the flags it owns. Every other flag is copied from its input. The file array belongs to the test fixture, so a fill port lets the environment seed any entry before operations use it. All outputs are registered and appear one clock after the inputs are sampled.

Top module: `fxu_exec`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge. Reset does not clear the file array.
- R2: For an accepted operation (`valid_i`=1, `fill_i`=0), `dest_i`=1 gives `f_we_o`=1 and `w_we_o`=0 and stores `res_o` into the file entry at `faddr_i`. `dest_i`=0 gives `w_we_o`=1 and `f_we_o`=0 and leaves that entry unchanged.
- R3: `op_i`=0 rotates left through carry. The result is `{opnd[6:0], c_i}`, `c_o` is `opnd[7]`, and DC and Z are copied from the inputs.
- R4: `op_i`=1 rotates right through carry. The result is `{c_i, opnd[7:1]}`, `c_o` is `opnd[0]`, and DC and Z are copied from the inputs.
- R5: `op_i`=2 computes (opnd - `w_i`) mod 256. `c_o`=1 when opnd >= `w_i`, meaning no borrow. `dc_o`=1 when opnd[3:0] >= `w_i[3:0]`.
- R6: For `op_i`=2, `z_o` is 1 exactly when the 8-bit difference is zero.
- R7: `op_i`=3 outputs `{opnd[3:0], opnd[7:4]}`, and C, DC and Z are all copied from the inputs.
- R8: When `valid_i`=0 and `fill_i`=0, both write strobes are 0 after the edge, `res_o` and the flag outputs keep their values, and no file entry changes.
- R9: `fill_i`=1 writes `fill_data_i` into the entry at `faddr_i`. It takes priority over `valid_i`, so both strobes are 0 and the result and flag outputs hold.
- R10: All 32 file addresses are independent. A write to one entry leaves every other entry unchanged.
- R11: Outputs change only on a clock edge and reflect the inputs and file contents sampled at that edge. An entry written at one edge is the operand seen at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Issue an operation this cycle |
| op_i | input | 2 | 0 rotate left, 1 rotate right, 2 subtract, 3 nibble swap |
| faddr_i | input | 5 | File entry address (0 to 31) |
| dest_i | input | 1 | 1 writes the file entry, 0 targets the working register |
| w_i | input | 8 | Working-register value |
| c_i | input | 1 | Carry flag in |
| dc_i | input | 1 | Digit-carry flag in |
| z_i | input | 1 | Zero flag in |
| fill_i | input | 1 | Seed the file entry at `faddr_i` |
| fill_data_i | input | 8 | Seed byte |
| res_o | output | 8 | Registered result byte |
| w_we_o | output | 1 | Load the working register with `res_o` |
| f_we_o | output | 1 | Result was stored into the file entry |
| c_o | output | 1 | Carry flag out |
| dc_o | output | 1 | Digit-carry flag out |
| z_o | output | 1 | Zero flag out |

## Verification
The hardest case to reach from the ports is the subtract where the full byte does not borrow but the low nibble does, or the reverse. This is the only situation where `c_o` and `dc_o` disagree. The stimulus seeds file entries with chosen bytes and pairs them with working-register values such as 0x21 minus 0x12 and 0x12 minus 0x21, then sweeps random operands over all addresses. It also checks that a result with `dest_i`=0 did not reach the file: a later subtract of zero, which returns the operand unchanged, reads the entry back.

// File: rtl/fxu_pkg.sv
package fxu_pkg;
  typedef enum logic [1:0] {
    FXU_RLC  = 2'd0,
    FXU_RRC  = 2'd1,
    FXU_SUB  = 2'd2,
    FXU_SWAP = 2'd3
  } fxu_op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } fxu_flags_t;
endpackage

// File: rtl/fxu_regfile.sv
// File-register array: synchronous write, combinational read (LUT RAM).
module fxu_regfile #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fxu_rotate.sv
// One-position rotate through carry; LEFT selects the direction.
module fxu_rotate #(
  parameter int DW   = 8,
  parameter bit LEFT = 1'b1
) (
  input  logic [DW-1:0] din,
  input  logic          cin,
  output logic [DW-1:0] dout,
  output logic          cout
);
  generate
    if (LEFT) begin : g_left
      assign dout = {din[DW-2:0], cin};
      assign cout = din[DW-1];
    end else begin : g_right
      assign dout = {cin, din[DW-1:1]};
      assign cout = din[0];
    end
  endgenerate
endmodule

// File: rtl/fxu_sub.sv
// Subtract b from a; reports no-borrow for full width and low nibble.
module fxu_sub #(
  parameter int DW = 8,
  parameter int NW = DW / 2
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] diff,
  output logic          no_borrow,
  output logic          nib_no_borrow,
  output logic          zero
);
  logic [DW:0] full;
  logic [NW:0] low;

  always_comb begin
    full          = {1'b0, a} - {1'b0, b};
    low           = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]};
    diff          = full[DW-1:0];
    no_borrow     = ~full[DW];
    nib_no_borrow = ~low[NW];
    zero          = (full[DW-1:0] == '0);
  end
endmodule

// File: rtl/fxu_alu.sv
// Combinational operation select with per-operation flag ownership.
module fxu_alu
  import fxu_pkg::*;
#(
  parameter int DW = 8
) (
  input  fxu_op_e       op,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] wreg,
  input  fxu_flags_t    fin,
  output logic [DW-1:0] res,
  output fxu_flags_t    fout
);
  localparam int NW = DW / 2;

  logic [DW-1:0] rl_q, rr_q, sub_q, swp_q;
  logic          rl_c, rr_c, sub_c, sub_dc, sub_z;

  fxu_rotate #(.DW(DW), .LEFT(1'b1)) u_rl (
    .din(opnd), .cin(fin.c), .dout(rl_q), .cout(rl_c)
  );

  fxu_rotate #(.DW(DW), .LEFT(1'b0)) u_rr (
    .din(opnd), .cin(fin.c), .dout(rr_q), .cout(rr_c)
  );

  fxu_sub #(.DW(DW), .NW(NW)) u_sub (
    .a(opnd), .b(wreg), .diff(sub_q),
    .no_borrow(sub_c), .nib_no_borrow(sub_dc), .zero(sub_z)
  );

  assign swp_q = {opnd[NW-1:0], opnd[DW-1:NW]};

  always_comb begin
    fout = fin;
    res  = swp_q;
    unique case (op)
      FXU_RLC: begin
        res    = rl_q;
        fout.c = rl_c;
      end
      FXU_RRC: begin
        res    = rr_q;
        fout.c = rr_c;
      end
      FXU_SUB: begin
        res     = sub_q;
        fout.c  = sub_c;
        fout.dc = sub_dc;
        fout.z  = sub_z;
      end
      default: res = swp_q;
    endcase
  end
endmodule

// File: rtl/fxu_exec.sv
// Execute unit top: file array, ALU and registered outputs.
module fxu_exec
  import fxu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] faddr_i,
  input  logic          dest_i,
  input  logic [DW-1:0] w_i,
  input  logic          c_i,
  input  logic          dc_i,
  input  logic          z_i,
  input  logic          fill_i,
  input  logic [DW-1:0] fill_data_i,
  output logic [DW-1:0] res_o,
  output logic          w_we_o,
  output logic          f_we_o,
  output logic          c_o,
  output logic          dc_o,
  output logic          z_o
);
  logic [DW-1:0] opnd, alu_res, rf_wdata;
  fxu_flags_t    fin, fout;
  logic          take, rf_we;

  assign take     = valid_i & ~fill_i & ~rst;
  assign rf_we    = ~rst & (fill_i | (take & dest_i));
  assign rf_wdata = fill_i ? fill_data_i : alu_res;
  assign fin      = '{c: c_i, dc: dc_i, z: z_i};

  fxu_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk(clk), .we(rf_we), .waddr(faddr_i), .wdata(rf_wdata),
    .raddr(faddr_i), .rdata(opnd)
  );

  fxu_alu #(.DW(DW)) u_alu (
    .op(fxu_op_e'(op_i)), .opnd(opnd), .wreg(w_i), .fin(fin),
    .res(alu_res), .fout(fout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      w_we_o <= 1'b0;
      f_we_o <= 1'b0;
      c_o    <= 1'b0;
      dc_o   <= 1'b0;
      z_o    <= 1'b0;
    end else begin
      w_we_o <= take & ~dest_i;
      f_we_o <= take & dest_i;
      if (take) begin
        res_o <= alu_res;
        c_o   <= fout.c;
        dc_o  <= fout.dc;
        z_o   <= fout.z;
      end
    end
  end
endmodule

// File: rtl/fxu_exec_chk.sv
module fxu_exec_chk #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          valid_i,
  input logic [1:0]    op_i,
  input logic [AW-1:0] faddr_i,
  input logic          dest_i,
  input logic [DW-1:0] w_i,
  input logic          c_i,
  input logic          dc_i,
  input logic          z_i,
  input logic          fill_i,
  input logic [DW-1:0] fill_data_i,
  input logic [DW-1:0] res_o,
  input logic          w_we_o,
  input logic          f_we_o,
  input logic          c_o,
  input logic          dc_o,
  input logic          z_o
);
  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    !(w_we_o && f_we_o));

  a_r2_dest_routes: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(valid_i && !fill_i)) |->
      (f_we_o == $past(dest_i)) && (w_we_o == !$past(dest_i)));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!valid_i || fill_i)) |->
      (!w_we_o && !f_we_o && $stable(res_o) && $stable(c_o)
       && $stable(dc_o) && $stable(z_o)));

  a_r3_rotl_carry_in: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(valid_i && !fill_i && op_i == 2'd0)) |->
      (res_o[0] == $past(c_i)) && (dc_o == $past(dc_i)) && (z_o == $past(z_i)));

  a_r4_rotr_carry_in: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(valid_i && !fill_i && op_i == 2'd1)) |->
      (res_o[DW-1] == $past(c_i)) && (dc_o == $past(dc_i)) && (z_o == $past(z_i)));

  a_r6_sub_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(valid_i && !fill_i && op_i == 2'd2)) |->
      (z_o == (res_o == '0)));

  a_r7_swap_flags: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(valid_i && !fill_i && op_i == 2'd3)) |->
      (c_o == $past(c_i)) && (dc_o == $past(dc_i)) && (z_o == $past(z_i)));
endmodule

bind fxu_exec fxu_exec_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .faddr_i(faddr_i),
  .dest_i(dest_i), .w_i(w_i), .c_i(c_i), .dc_i(dc_i), .z_i(z_i),
  .fill_i(fill_i), .fill_data_i(fill_data_i), .res_o(res_o),
  .w_we_o(w_we_o), .f_we_o(f_we_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o)
);

// File: tb/sim_fxu_exec.sv
`timescale 1ns/1ps
module sim_fxu_exec;
  logic       clk = 1'b0;
  logic       rst;
  logic       valid_i, dest_i, c_i, dc_i, z_i, fill_i;
  logic [1:0] op_i;
  logic [4:0] faddr_i;
  logic [7:0] w_i, fill_data_i;
  logic [7:0] res_o;
  logic       w_we_o, f_we_o, c_o, dc_o, z_o;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  int mem [32];
  int e_res, e_c, e_dc, e_z, e_ww, e_fw;

  always #5 clk = ~clk;

  fxu_exec u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .faddr_i(faddr_i),
    .dest_i(dest_i), .w_i(w_i), .c_i(c_i), .dc_i(dc_i), .z_i(z_i),
    .fill_i(fill_i), .fill_data_i(fill_data_i), .res_o(res_o),
    .w_we_o(w_we_o), .f_we_o(f_we_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o)
  );

  // Reference model: next registered outputs from the current inputs.
  task automatic model();
    int o, r;
    if (rst) begin
      e_res = 0; e_c = 0; e_dc = 0; e_z = 0; e_ww = 0; e_fw = 0;
    end else if (fill_i) begin
      mem[faddr_i] = fill_data_i;
      e_ww = 0; e_fw = 0;
    end else if (valid_i) begin
      o = mem[faddr_i];
      e_c = c_i; e_dc = dc_i; e_z = z_i;
      case (op_i)
        2'd0: begin r = ((o * 2) + c_i) % 256; e_c = o / 128; end
        2'd1: begin r = (o / 2) + (c_i * 128); e_c = o % 2; end
        2'd2: begin
          r = (o - w_i + 256) % 256;
          e_c = (o >= w_i); e_dc = ((o % 16) >= (w_i % 16)); e_z = (r == 0);
        end
        default: r = (o % 16) * 16 + (o / 16);
      endcase
      e_res = r;
      e_ww = !dest_i; e_fw = dest_i;
      if (dest_i) mem[faddr_i] = r;
    end else begin
      e_ww = 0; e_fw = 0;
    end
  endtask

  task automatic step(input string tag);
    logic [13:0] act, exp;
    model();
    @(posedge clk);
    @(negedge clk);
    act = {res_o, w_we_o, f_we_o, c_o, dc_o, z_o};
    exp = {e_res[7:0], e_ww[0], e_fw[0], e_c[0], e_dc[0], e_z[0]};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (res,wwe,fwe,c,dc,z)", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag, input int op, input int a, input int d,
                       input int w, input int c, input int dc, input int z);
    valid_i = 1; fill_i = 0; op_i = op[1:0]; faddr_i = a[4:0]; dest_i = d[0];
    w_i = w[7:0]; c_i = c[0]; dc_i = dc[0]; z_i = z[0];
    step(tag);
    valid_i = 0;
  endtask

  task automatic fill(input string tag, input int a, input int v);
    fill_i = 1; valid_i = 0; faddr_i = a[4:0]; fill_data_i = v[7:0];
    step(tag);
    fill_i = 0;
  endtask

  initial begin
    rst = 1; valid_i = 0; fill_i = 0; op_i = 0; faddr_i = 0; dest_i = 0;
    w_i = 0; c_i = 0; dc_i = 0; z_i = 0; fill_data_i = 0;
    @(negedge clk);
    step("R1 reset");
    step("R1 reset");
    rst = 0;
    for (int a = 0; a < 32; a++) fill("R9 seed", a, (a * 37 + 11) % 256);
    for (int a = 0; a < 32; a++) issue("R10 readback", 2, a, 0, 0, 0, 0, 0);
    // R3 rotate left
    fill("R9", 1, 8'h81);
    issue("R3 rl c0", 0, 1, 0, 0, 0, 1, 1);
    issue("R3 rl c1 dest f", 0, 1, 1, 0, 1, 0, 0);
    issue("R11 readback", 2, 1, 0, 0, 1, 1, 1);
    // R4 rotate right
    issue("R4 rr c1", 1, 2, 0, 0, 1, 0, 1);
    issue("R4 rr c0 dest f", 1, 2, 1, 0, 0, 1, 0);
    // R5/R6 subtract corners
    fill("R9", 3, 8'h21);
    issue("R5 c=1 dc=0", 2, 3, 0, 8'h12, 0, 1, 1);
    fill("R9", 4, 8'h12);
    issue("R5 c=0 dc=1", 2, 4, 0, 8'h21, 1, 0, 1);
    issue("R6 zero", 2, 4, 0, 8'h12, 0, 0, 0);
    issue("R5 borrow", 2, 4, 0, 8'hFF, 1, 1, 1);
    // R7 swap, flags pass through
    issue("R7 swap", 3, 5, 0, 0, 1, 0, 1);
    issue("R7 swap dest f", 3, 5, 1, 0, 0, 1, 0);
    // R2 dest=0 leaves file alone
    issue("R2 dest w", 3, 6, 0, 0, 0, 0, 0);
    issue("R2 readback", 2, 6, 0, 0, 0, 0, 0);
    // R8 idle
    valid_i = 0; w_i = 8'h55; c_i = 1;
    step("R8 idle");
    step("R8 idle");
    issue("R8 readback", 2, 6, 0, 0, 0, 0, 0);
    // R9 fill beats valid
    valid_i = 1; fill_i = 1; faddr_i = 7; fill_data_i = 8'hC3; op_i = 0; dest_i = 1;
    step("R9 priority");
    fill_i = 0; valid_i = 0;
    issue("R9 readback", 2, 7, 0, 0, 0, 0, 0);
    // Random sweep
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 3);
      int k  = $urandom_range(0, 9);
      if (k == 0) fill("R9 rand", $urandom_range(0, 31), $urandom_range(0, 255));
      else if (k == 1) begin valid_i = 0; step("R8 rand"); end
      else issue(op == 0 ? "R3 rand" : op == 1 ? "R4 rand" : op == 2 ? "R5 rand" : "R7 rand",
                 op, $urandom_range(0, 31), $urandom_range(0, 1), $urandom_range(0, 255),
                 $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end
    rst = 1;
    step("R1 reset again");
    rst = 0;
    issue("R11 file kept over reset", 2, 7, 0, 0, 0, 0, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule